// File: doc/BRIEF.md
# DLL Bring-Up and Restart Sequencer

This controller-side block decides when a synchronous memory with an internal delay-locked loop may carry traffic. It keeps the memory's DLL enable level low until the board reports good supplies and a stable input clock. It then releases the DLL and counts the lock interval. After the lock interval it declares the memory ready. Reads stay blocked until the output drivers have seen enough cycles with no read to settle their impedance. That count only runs while the memory is ready.

The block also handles two kinds of restart. A power-saving clock stop gates the memory clock for at least a minimum time and then waits a shorter restart interval. A frequency change, or a loss of clock stability, forces a clock stop of at least the minimum time so that the DLL resets. A complete new lock interval follows. Any command issued while the memory is not ready raises a sticky error flag. A read issued before reads are permitted raises the same flag. All intervals are counted on the free-running reference clock `clk`.

Top module: `dll_bringup_seq`

## Requirements
- R1: After reset all outputs are low. `dll_on` stays low for as long as `pwr_good` or `clk_stable` is low.
- R2: `dll_on` goes high at the first clock edge that samples both `pwr_good` and `clk_stable` high.
- R3: After `dll_on` rises, `ready` rises once `LOCK_CYCLES` cycles have passed. During those cycles `dll_on` is high and `ready` is low.
- R4: `read_ok` rises only after `ZQ_CYCLES` ready cycles have been sampled with no read command (`cmd_valid`=1 and `cmd_is_read`=1). A ready cycle that carries a read does not count. `read_ok` is never high unless `ready` is high.
- R5: When `stop_req` is sampled high while ready, `clk_stop` goes high and `ready` goes low at the next edge. `clk_stop` stays high for the longer of `STOP_CYCLES` cycles and the time `stop_req` is held.
- R6: After a power-saving stop ends, `ready` returns after exactly `RESTART_CYCLES` cycles with `clk_stop` low. `read_ok` returns together with `ready`, because impedance settling is kept.
- R7: A `freq_change` pulse while locking or ready gives `STOP_CYCLES` cycles of `clk_stop` with `dll_on` held high. A full `LOCK_CYCLES` lock interval follows.
- R8: If `clk_stable` drops while locking or ready, `clk_stop` is held until `clk_stable` returns and for at least `STOP_CYCLES` cycles. A full lock interval follows.
- R9: If `pwr_good` is sampled low, `dll_on` and `ready` are low at the next edge. A later bring-up repeats the whole lock interval and the whole impedance-settling count.
- R10: `cmd_err` is set at the edge after a command sampled while `ready` is low, or after a read sampled while `read_ok` is low. Once set, it stays high until reset. A write while ready leaves it low.
- R11: `dll_on` falls only at an edge that sampled `pwr_good` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Supplies are up and stable |
| clk_stable | input | 1 | Memory input clock is stable |
| freq_change | input | 1 | Pulse: operating frequency is about to change |
| stop_req | input | 1 | Request a power-saving clock stop |
| cmd_valid | input | 1 | Controller issues a command this cycle |
| cmd_is_read | input | 1 | Command is a read (1) or a write (0) |
| dll_on | output | 1 | DLL enable level to the memory; low keeps the DLL disabled |
| ready | output | 1 | DLL locked and memory clock running |
| read_ok | output | 1 | Reads permitted (ready and impedance settled) |
| clk_stop | output | 1 | Forced stop of the memory clock |
| cmd_err | output | 1 | Sticky error: command issued too early |

## Verification
The assertions assume `pwr_good` and `clk_stable` are level signals that change at most once per cycle. They assume `freq_change` is a single-cycle pulse. They assume the checker sees the same clock as the counters, so the minimum stop is measured in reference cycles. The stimulus changes every input only on the falling edge. It holds `stop_req` for either less or more than the minimum stop time so that both bounds of R5 are exercised. It issues the early commands that R10 forbids only in steps where the error flag is what is being checked.

// File: rtl/dll_seq_pkg.sv
package dll_seq_pkg;

  typedef enum logic [2:0] {
    ST_OFF     = 3'd0,
    ST_LOCK    = 3'd1,
    ST_RUN     = 3'd2,
    ST_STOP    = 3'd3,
    ST_RESTART = 3'd4,
    ST_RESET   = 3'd5
  } seq_state_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // Terminal count of the phase counter for each timed state.
  function automatic int phase_limit(input seq_state_e st, input int lock_c,
                                     input int restart_c, input int stop_c);
    case (st)
      ST_LOCK:            return lock_c - 1;
      ST_RESTART:         return restart_c - 1;
      ST_STOP, ST_RESET:  return stop_c - 1;
      default:            return 0;
    endcase
  endfunction

endpackage

// File: rtl/dll_seq_counter.sv
module dll_seq_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] limit,
  output logic [W-1:0] cnt,
  output logic         at_limit
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (clr)               cnt_q <= '0;
    else if (en && !at_limit)   cnt_q <= cnt_q + {{(W-1){1'b0}}, 1'b1};
  end

  assign at_limit = (cnt_q == limit);
  assign cnt      = cnt_q;
endmodule

// File: rtl/dll_seq_fsm.sv
module dll_seq_fsm
  import dll_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_good,
  input  logic       clk_stable,
  input  logic       freq_change,
  input  logic       stop_req,
  input  logic       phase_done,
  output seq_state_e state,
  output logic       state_change
);
  seq_state_e st_q, st_d;
  logic       dll_reset_cause;

  assign dll_reset_cause = !clk_stable || freq_change;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_OFF:     if (pwr_good && clk_stable) st_d = ST_LOCK;
      ST_LOCK:    if (dll_reset_cause)        st_d = ST_RESET;
                  else if (phase_done)        st_d = ST_RUN;
      ST_RUN:     if (dll_reset_cause)        st_d = ST_RESET;
                  else if (stop_req)          st_d = ST_STOP;
      ST_STOP:    if (!stop_req && phase_done) st_d = ST_RESTART;
      ST_RESTART: if (dll_reset_cause)        st_d = ST_RESET;
                  else if (phase_done)        st_d = ST_RUN;
      ST_RESET:   if (clk_stable && phase_done) st_d = ST_LOCK;
      default:                                st_d = ST_OFF;
    endcase
    if (!pwr_good) st_d = ST_OFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_OFF;
    else        st_q <= st_d;
  end

  assign state        = st_q;
  assign state_change = (st_d != st_q);
endmodule

// File: rtl/dll_bringup_seq.sv
module dll_bringup_seq
  import dll_seq_pkg::*;
#(
  parameter int LOCK_CYCLES    = 2048,
  parameter int RESTART_CYCLES = 1024,
  parameter int ZQ_CYCLES      = 1024,
  parameter int STOP_CYCLES    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good,
  input  logic clk_stable,
  input  logic freq_change,
  input  logic stop_req,
  input  logic cmd_valid,
  input  logic cmd_is_read,
  output logic dll_on,
  output logic ready,
  output logic read_ok,
  output logic clk_stop,
  output logic cmd_err
);
  localparam int PHASE_MAX = max3(LOCK_CYCLES, RESTART_CYCLES, STOP_CYCLES);
  localparam int PW        = $clog2(PHASE_MAX + 1);
  localparam int ZW        = $clog2(ZQ_CYCLES + 1);

  seq_state_e    state;
  logic          state_change;
  logic [PW-1:0] phase_lim, phase_cnt;
  logic          phase_done;
  logic [ZW-1:0] zq_cnt;
  logic          zq_done;
  logic          read_cmd, zq_count_en, early_cmd;
  logic          err_q;

  assign phase_lim = PW'(phase_limit(state, LOCK_CYCLES, RESTART_CYCLES, STOP_CYCLES));

  dll_seq_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwr_good     (pwr_good),
    .clk_stable   (clk_stable),
    .freq_change  (freq_change),
    .stop_req     (stop_req),
    .phase_done   (phase_done),
    .state        (state),
    .state_change (state_change)
  );

  dll_seq_counter #(.W(PW)) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (state_change),
    .en       (1'b1),
    .limit    (phase_lim),
    .cnt      (phase_cnt),
    .at_limit (phase_done)
  );

  // Impedance settling: non-read cycles while ready, restarted on power loss.
  assign read_cmd    = cmd_valid && cmd_is_read;
  assign zq_count_en = ready && !read_cmd;

  dll_seq_counter #(.W(ZW)) u_zq (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (state == ST_OFF),
    .en       (zq_count_en),
    .limit    (ZW'(ZQ_CYCLES)),
    .cnt      (zq_cnt),
    .at_limit (zq_done)
  );

  assign dll_on   = (state != ST_OFF);
  assign ready    = (state == ST_RUN);
  assign clk_stop = (state == ST_STOP) || (state == ST_RESET);
  assign read_ok  = ready && zq_done;

  assign early_cmd = cmd_valid && (!ready || (cmd_is_read && !read_ok));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_q || early_cmd;
  end

  assign cmd_err = err_q;

  logic unused_cnt;
  assign unused_cnt = ^{phase_cnt, zq_cnt};
endmodule

// File: rtl/dll_bringup_seq_chk.sv
module dll_bringup_seq_chk #(
  parameter int STOP_CYCLES = 2
) (
  input logic clk,
  input logic rst_n,
  input logic pwr_good,
  input logic clk_stable,
  input logic cmd_valid,
  input logic dll_on,
  input logic ready,
  input logic read_ok,
  input logic clk_stop,
  input logic cmd_err
);
  int stop_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         stop_run <= 0;
    else if (!clk_stop)                 stop_run <= 0;
    else if (stop_run < STOP_CYCLES)    stop_run <= stop_run + 1;
  end

  assert_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!dll_on && !(pwr_good && clk_stable)) |=> !dll_on);

  assert_pwr_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> (!dll_on && !ready));

  assert_dll_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dll_on) |-> !$past(pwr_good));

  assert_readok_R4: assert property (@(posedge clk) disable iff (!rst_n)
    read_ok |-> ready);

  assert_stop_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clk_stop |-> !ready);

  assert_stop_min_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_stop) |-> (stop_run >= STOP_CYCLES));

  assert_err_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !ready) |=> cmd_err);

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |=> cmd_err);
endmodule

bind dll_bringup_seq dll_bringup_seq_chk #(.STOP_CYCLES(STOP_CYCLES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pwr_good   (pwr_good),
  .clk_stable (clk_stable),
  .cmd_valid  (cmd_valid),
  .dll_on     (dll_on),
  .ready      (ready),
  .read_ok    (read_ok),
  .clk_stop   (clk_stop),
  .cmd_err    (cmd_err)
);

// File: tb/dll_bringup_seq_bench.sv
module dll_bringup_seq_bench;
  localparam int LOCK    = 2048;
  localparam int RESTART = 1024;
  localparam int ZQ      = 1024;
  localparam int STOPC   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_good = 1'b0, clk_stable = 1'b0, freq_change = 1'b0, stop_req = 1'b0;
  logic cmd_valid = 1'b0, cmd_is_read = 1'b0;
  logic dll_on, ready, read_ok, clk_stop, cmd_err;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  dll_bringup_seq #(
    .LOCK_CYCLES(LOCK), .RESTART_CYCLES(RESTART),
    .ZQ_CYCLES(ZQ), .STOP_CYCLES(STOPC)
  ) u_dll_bringup_seq (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .clk_stable(clk_stable),
    .freq_change(freq_change), .stop_req(stop_req), .cmd_valid(cmd_valid),
    .cmd_is_read(cmd_is_read), .dll_on(dll_on), .ready(ready),
    .read_ok(read_ok), .clk_stop(clk_stop), .cmd_err(cmd_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // 0: locking, 1: clock stopped, 2: restarting after a stop
  function automatic bit in_phase(input int mode);
    case (mode)
      0:       return dll_on && !ready && !clk_stop;
      1:       return clk_stop;
      default: return !ready && !clk_stop && dll_on;
    endcase
  endfunction

  task automatic count_phase(input int mode, output int k);
    k = 0;
    while (in_phase(mode) && k < 20000) begin
      k++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(!dll_on && !ready && !read_ok && !clk_stop && !cmd_err, "R1 reset outputs",
        {dll_on, ready, read_ok, clk_stop, cmd_err}, 0);
  endtask

  task automatic t_gate;
    pwr_good = 1'b1;
    repeat (10) @(negedge clk);
    chk(!dll_on, "R1 dll held low without clk_stable", dll_on, 0);
    clk_stable = 1'b1;
    @(negedge clk);
    chk(dll_on, "R2 dll released", dll_on, 1);
    chk(!ready, "R3 not ready at release", ready, 0);
  endtask

  task automatic t_lock(input string req);
    int k;
    count_phase(0, k);
    chk(k == LOCK, req, k, LOCK);
    chk(ready, req, ready, 1);
  endtask

  task automatic t_settle;
    int k;
    chk(!read_ok, "R4 reads blocked at first ready", read_ok, 0);
    cmd_valid = 1'b1; cmd_is_read = 1'b0;
    @(negedge clk);
    chk(!cmd_err, "R10 write while ready", cmd_err, 0);
    cmd_is_read = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_is_read = 1'b0;
    chk(cmd_err, "R10 early read", cmd_err, 1);
    k = 2;
    while (!read_ok && k < 5000) begin
      @(negedge clk);
      k++;
    end
    chk(k == ZQ + 1, "R4 settle count with one read", k, ZQ + 1);
  endtask

  task automatic t_stop_short;
    int k;
    stop_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
    chk(clk_stop && !ready && !read_ok, "R5 stop entered", clk_stop, 1);
    count_phase(1, k);
    chk(k == STOPC, "R5 minimum stop length", k, STOPC);
    count_phase(2, k);
    chk(k == RESTART, "R6 restart interval", k, RESTART);
    chk(ready && read_ok, "R6 reads return with ready", read_ok, 1);
  endtask

  task automatic t_stop_long;
    int k;
    k = 0;
    stop_req = 1'b1;
    repeat (10) begin
      @(negedge clk);
      if (clk_stop) k++;
    end
    stop_req = 1'b0;
    @(negedge clk);
    chk(k == 10 && !clk_stop, "R5 stop follows long request", k, 10);
    count_phase(2, k);
    chk(k == RESTART, "R6 restart after long stop", k, RESTART);
  endtask

  task automatic t_freq;
    int k;
    freq_change = 1'b1;
    @(negedge clk);
    freq_change = 1'b0;
    chk(clk_stop && dll_on, "R7 stop on frequency change", clk_stop, 1);
    count_phase(1, k);
    chk(k == STOPC, "R7 DLL reset stop length", k, STOPC);
    t_lock("R7 full relock");
  endtask

  task automatic t_unstable;
    int k;
    clk_stable = 1'b0;
    @(negedge clk);
    chk(clk_stop && !ready, "R8 stop on unstable clock", clk_stop, 1);
    repeat (7) @(negedge clk);
    clk_stable = 1'b1;
    count_phase(1, k);
    chk(7 + k == 8, "R8 stop held while unstable", 7 + k, 8);
    t_lock("R8 full relock");
  endtask

  task automatic t_power;
    int k;
    pwr_good = 1'b0;
    @(negedge clk);
    pwr_good = 1'b1;
    chk(!dll_on && !ready && !read_ok, "R9 power loss", dll_on, 0);
    @(negedge clk);
    chk(dll_on, "R9 re-release", dll_on, 1);
    t_lock("R9 relock after power loss");
    chk(!read_ok, "R9 settling restarted", read_ok, 0);
    k = 0;
    while (!read_ok && k < 5000) begin
      @(negedge clk);
      k++;
    end
    chk(k == ZQ, "R4 settle count without reads", k, ZQ);
  endtask

  task automatic t_err_idle;
    pwr_good = 1'b0; clk_stable = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!cmd_err, "R10 cleared by reset", cmd_err, 0);
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(cmd_err, "R10 command while not ready", cmd_err, 1);
    repeat (5) @(negedge clk);
    chk(cmd_err, "R10 flag sticky", cmd_err, 1);
    chk(!dll_on, "R1 dll low without power", dll_on, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_gate();
    t_lock("R3 lock interval");
    t_settle();
    t_stop_short();
    t_stop_long();
    t_freq();
    t_unstable();
    t_power();
    t_err_idle();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule